// File: doc/BRIEF.md
# Validation Coprocessor with Timed Interrupt Generation

This block sits beside a CPU core as a coprocessor used for validation. It holds a file of sixteen 32-bit registers. The CPU writes and reads these registers with register move commands, and moves words in and out with block load and store commands. Each command arrives as a one-cycle strobe that carries a command kind, a 32-bit instruction word and a write-data word. The block answers in that same cycle with a 2-bit response code and, for reads, the read data.

Data-operation commands take a 4-bit opcode and an operand register index from the instruction word. The value held in the operand register acts as a cycle count or as a destination. A data-operation can stall the CPU for that many cycles. It can also arm a delayed fast interrupt or normal interrupt, release either interrupt line, or copy a free-running 32-bit cycle counter into the operand register. A count of zero takes effect at once. The interrupt outputs are active low.

Top module: `valcop_top`

## Requirements
- R1: A synchronous active-high reset clears every register to zero, sets the cycle counter to zero, drives fiq_n and irq_n high and leaves no busy wait in progress.
- R2: A register move write (kind 0) stores cmd_wdata into the register selected by instruction bits 19:16. A register move read (kind 1) returns that register on rsp_rdata in the same cycle.
- R3: A block load (kind 2) stores cmd_wdata into the register selected by instruction bits 15:12. A block store (kind 3) returns that register on rsp_rdata in the same cycle. Bits 19:16 play no part in either.
- R4: The response code is valid in the strobe cycle: 0 done, 1 busy, 2 cannot execute. A data-operation (kind 4) whose opcode in bits 23:20 is above 5, or a command kind above 4, gets code 2 and changes no register.
- R5: Opcode 0 with count n (the operand register selected by bits 3:0) answers busy in the strobe cycle and the next n-1 cycles, then done in cycle n. The finish test uses wrap-safe subtraction on the cycle counter. A count of zero answers done at once and starts no wait.
- R6: While a busy wait is in progress, incoming strobes are ignored: they write nothing, and the response shows the wait status.
- R7: Opcode 1 with count n drives fiq_n low from the (n+1)-th cycle after the strobe cycle. With n = 0 that is the cycle right after the strobe.
- R8: Opcode 2 does the same for irq_n.
- R9: Opcode 3 releases fiq_n high and opcode 4 releases irq_n high from the next cycle. Each also cancels a pending schedule of its kind.
- R10: A new schedule of one kind that arrives while the same kind is pending replaces the pending delay. The line then falls n+1 cycles after the new strobe.
- R11: The cycle counter increments every clock and wraps modulo 2^32. Opcode 5 writes the counter value of the strobe cycle into the operand register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_kind | input | 3 | 0 move write, 1 move read, 2 block load, 3 block store, 4 data-operation |
| cmd_instr | input | 32 | Instruction word carrying register indices and opcode |
| cmd_wdata | input | 32 | Data for move write and block load |
| rsp_code | output | 2 | 0 done, 1 busy, 2 cannot execute |
| rsp_rdata | output | 32 | Read data for move read and block store |
| fiq_n | output | 1 | Fast interrupt request, active low |
| irq_n | output | 1 | Normal interrupt request, active low |

## Verification
The bench counts the busy wait to the exact cycle. A design with an off-by-one finish compare answers done one cycle early or late, and a zero-count wait that is not special-cased hangs in busy. Each interrupt delay is checked cycle by cycle around its falling edge. Two further cases target the schedule state: a release that arrives while a schedule is pending must stop the line from falling, and a later, longer schedule must move the fall point back rather than keep the first. Writes presented during a wait must not land, the register index fields must not be swapped between move and block commands, and the snapshot must match the strobe cycle, not the cycle after it.

// File: rtl/cop_pkg.sv
`timescale 1ns/1ps
package cop_pkg;
    localparam int DW       = 32;
    localparam int NREG     = 16;
    localparam int IDXW     = $clog2(NREG);
    localparam int OPCW     = 4;
    localparam int MOV_LSB  = 16;
    localparam int BLK_LSB  = 12;
    localparam int OPC_LSB  = 20;
    localparam int OPND_LSB = 0;
    localparam int NCHAN    = 2;   // channel 0 = fast, 1 = normal

    typedef enum logic [2:0] {
        K_MOVE_WR = 3'd0,
        K_MOVE_RD = 3'd1,
        K_BLK_LD  = 3'd2,
        K_BLK_ST  = 3'd3,
        K_DATAOP  = 3'd4
    } cmd_kind_e;

    typedef enum logic [1:0] {
        RSP_DONE = 2'd0,
        RSP_BUSY = 2'd1,
        RSP_CANT = 2'd2
    } rsp_e;

    typedef enum logic [OPCW-1:0] {
        OP_WAIT    = 4'd0,
        OP_FIQ_SET = 4'd1,
        OP_IRQ_SET = 4'd2,
        OP_FIQ_CLR = 4'd3,
        OP_IRQ_CLR = 4'd4,
        OP_STAMP   = 4'd5
    } dop_e;

    typedef struct packed {
        logic            en;
        logic [IDXW-1:0] idx;
        logic [DW-1:0]   data;
    } wr_req_t;

    function automatic logic [IDXW-1:0] pick_idx(input logic [DW-1:0] word, input int lsb);
        return word[lsb +: IDXW];
    endfunction
endpackage

// File: rtl/cop_regfile.sv
`timescale 1ns/1ps
module cop_regfile
    import cop_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  wr_req_t         wr,
    input  logic [IDXW-1:0] ra_idx,
    input  logic [IDXW-1:0] rb_idx,
    output logic [DW-1:0]   ra_data,
    output logic [DW-1:0]   rb_data
);
    logic [DW-1:0] mem_q [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
        end else if (wr.en) begin
            mem_q[wr.idx] <= wr.data;
        end
    end

    assign ra_data = mem_q[ra_idx];
    assign rb_data = mem_q[rb_idx];

    // R2 / R3: an accepted write is visible through a read port next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr.en && ra_idx == wr.idx) |=> (mem_q[$past(wr.idx)] == $past(wr.data)));
endmodule

// File: rtl/cop_busy_wait.sv
`timescale 1ns/1ps
module cop_busy_wait
    import cop_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] count,
    input  logic [DW-1:0] now,
    output logic          waiting,
    output logic          still_busy
);
    logic          active_q;
    logic [DW-1:0] finish_q;
    logic [DW-1:0] slack;

    // wrap-safe: sign of (now - finish) decides, valid for counts below 2^(DW-1)
    assign slack      = now - finish_q;
    assign still_busy = active_q && slack[DW-1];
    assign waiting    = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            finish_q <= '0;
        end else if (start && count != '0) begin
            active_q <= 1'b1;
            finish_q <= now + count;
        end else if (active_q && !still_busy) begin
            active_q <= 1'b0;
        end
    end

    a_r5_done_ends_wait: assert property (@(posedge clk) disable iff (rst)
        (active_q && !still_busy && !start) |=> !waiting);
    a_r5_zero_never_waits: assert property (@(posedge clk) disable iff (rst)
        (!active_q && start && count == '0) |=> !waiting);
    a_r5_nonzero_waits: assert property (@(posedge clk) disable iff (rst)
        (!active_q && start && count != '0) |=> waiting);
endmodule

// File: rtl/cop_irq_timer.sv
`timescale 1ns/1ps
module cop_irq_timer
    import cop_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          disarm,
    input  logic [DW-1:0] delay,
    output logic          line_n
);
    logic          pend_q;
    logic          fired_q;
    logic [DW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            fired_q <= 1'b0;
            left_q  <= '0;
        end else if (disarm) begin
            pend_q  <= 1'b0;
            fired_q <= 1'b0;
        end else if (arm) begin
            if (delay == '0) begin
                fired_q <= 1'b1;
                pend_q  <= 1'b0;
            end else begin
                pend_q  <= 1'b1;
                left_q  <= delay;
            end
        end else if (pend_q) begin
            if (left_q == DW'(1)) begin
                fired_q <= 1'b1;
                pend_q  <= 1'b0;
            end else begin
                left_q  <= left_q - 1'b1;
            end
        end
    end

    assign line_n = !fired_q;

    a_r9_release_line: assert property (@(posedge clk) disable iff (rst)
        disarm |=> line_n);
    a_r7_zero_fires_now: assert property (@(posedge clk) disable iff (rst)
        (arm && !disarm && delay == '0) |=> !line_n);
    a_r10_rearm_holds_high: assert property (@(posedge clk) disable iff (rst)
        (arm && !disarm && delay > DW'(1) && line_n) |=> line_n);
endmodule

// File: rtl/valcop_top.sv
`timescale 1ns/1ps
module valcop_top
    import cop_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_kind,
    input  logic [31:0]   cmd_instr,
    input  logic [31:0]   cmd_wdata,
    output logic [1:0]    rsp_code,
    output logic [31:0]   rsp_rdata,
    output logic          fiq_n,
    output logic          irq_n
);
    logic [DW-1:0]   cnt_q;
    logic [IDXW-1:0] mov_idx, blk_idx, opnd_idx, ra_idx;
    logic [OPCW-1:0] opc;
    logic [DW-1:0]   ra_data, opnd_val;
    wr_req_t         wr;
    rsp_e            rsp;
    logic            start_wait, waiting, still_busy;
    logic [NCHAN-1:0] arm, disarm, line_n;
    logic            unused_bits;

    assign unused_bits = ^{cmd_instr[31:24], cmd_instr[11:4]};

    // free-running cycle counter
    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign mov_idx  = pick_idx(cmd_instr, MOV_LSB);
    assign blk_idx  = pick_idx(cmd_instr, BLK_LSB);
    assign opnd_idx = pick_idx(cmd_instr, OPND_LSB);
    assign opc      = cmd_instr[OPC_LSB +: OPCW];
    assign ra_idx   = (cmd_kind_e'(cmd_kind) == K_BLK_ST) ? blk_idx : mov_idx;

    always_comb begin
        rsp        = RSP_DONE;
        wr         = '0;
        start_wait = 1'b0;
        arm        = '0;
        disarm     = '0;
        if (waiting) begin
            rsp = still_busy ? RSP_BUSY : RSP_DONE;
        end else if (cmd_valid) begin
            unique case (cmd_kind_e'(cmd_kind))
                K_MOVE_WR: wr = '{en: 1'b1, idx: mov_idx, data: cmd_wdata};
                K_BLK_LD:  wr = '{en: 1'b1, idx: blk_idx, data: cmd_wdata};
                K_MOVE_RD, K_BLK_ST: rsp = RSP_DONE;
                K_DATAOP: begin
                    unique case (dop_e'(opc))
                        OP_WAIT: begin
                            start_wait = 1'b1;
                            rsp = (opnd_val == '0) ? RSP_DONE : RSP_BUSY;
                        end
                        OP_FIQ_SET: arm[0]    = 1'b1;
                        OP_IRQ_SET: arm[1]    = 1'b1;
                        OP_FIQ_CLR: disarm[0] = 1'b1;
                        OP_IRQ_CLR: disarm[1] = 1'b1;
                        OP_STAMP:   wr = '{en: 1'b1, idx: opnd_idx, data: cnt_q};
                        default:    rsp = RSP_CANT;
                    endcase
                end
                default: rsp = RSP_CANT;
            endcase
        end
    end

    cop_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .ra_idx  (ra_idx),
        .rb_idx  (opnd_idx),
        .ra_data (ra_data),
        .rb_data (opnd_val)
    );

    cop_busy_wait u_wait (
        .clk        (clk),
        .rst        (rst),
        .start      (start_wait),
        .count      (opnd_val),
        .now        (cnt_q),
        .waiting    (waiting),
        .still_busy (still_busy)
    );

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        cop_irq_timer u_tmr (
            .clk    (clk),
            .rst    (rst),
            .arm    (arm[c]),
            .disarm (disarm[c]),
            .delay  (opnd_val),
            .line_n (line_n[c])
        );
    end

    assign fiq_n     = line_n[0];
    assign irq_n     = line_n[1];
    assign rsp_code  = rsp;
    assign rsp_rdata = ra_data;

    a_r11_counter_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q == $past(cnt_q) + 1'b1));
    a_r4_code_legal: assert property (@(posedge clk) disable iff (rst)
        rsp_code != 2'd3);
    a_r6_no_write_in_wait: assert property (@(posedge clk) disable iff (rst)
        (waiting && cmd_valid) |-> (rsp_code != RSP_CANT && !wr.en));
    a_r1_lines_high_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (fiq_n && irq_n));
endmodule

// File: tb/tb_valcop_top.sv
`timescale 1ns/1ps
module tb_valcop_top;
    import cop_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_kind = '0;
    logic [31:0] cmd_instr = '0;
    logic [31:0] cmd_wdata = '0;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_rdata;
    logic        fiq_n, irq_n;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] tcyc = '0;

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) tcyc <= rst ? 32'd0 : tcyc + 32'd1;

    valcop_top dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_instr(cmd_instr), .cmd_wdata(cmd_wdata), .rsp_code(rsp_code),
        .rsp_rdata(rsp_rdata), .fiq_n(fiq_n), .irq_n(irq_n)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  kind;
        logic [31:0] instr;
        logic [31:0] wdata;
        logic [1:0]  rsp;
        logic        chk_rd;
        logic [31:0] rd;
    } vec_t;

    localparam int NV = 13;
    // instruction: [23:20] opcode, [19:16] move index, [15:12] block index, [3:0] operand
    localparam vec_t VEC [NV] = '{
        '{4'd2, 3'd0, 32'h0003_0000, 32'hA5A5_0F0F, 2'd0, 1'b0, 32'h0},          // R2 write r3
        '{4'd2, 3'd1, 32'h0003_0000, 32'h0,         2'd0, 1'b1, 32'hA5A5_0F0F},  // R2 read r3
        '{4'd3, 3'd2, 32'h0003_7000, 32'h1234_5678, 2'd0, 1'b0, 32'h0},          // R3 load r7
        '{4'd3, 3'd1, 32'h0003_0000, 32'h0,         2'd0, 1'b1, 32'hA5A5_0F0F},  // R3 r3 untouched
        '{4'd3, 3'd1, 32'h0007_0000, 32'h0,         2'd0, 1'b1, 32'h1234_5678},  // R3 r7 via move
        '{4'd3, 3'd3, 32'h000F_7000, 32'h0,         2'd0, 1'b1, 32'h1234_5678},  // R3 store r7
        '{4'd2, 3'd0, 32'h000F_0000, 32'hFFFF_FFFF, 2'd0, 1'b0, 32'h0},          // R2 write r15
        '{4'd3, 3'd3, 32'h0000_F000, 32'h0,         2'd0, 1'b1, 32'hFFFF_FFFF},  // R3 store r15
        '{4'd4, 3'd4, 32'h0093_0003, 32'h0,         2'd2, 1'b0, 32'h0},          // R4 opcode 9
        '{4'd4, 3'd4, 32'h00F3_0003, 32'h0,         2'd2, 1'b0, 32'h0},          // R4 opcode 15
        '{4'd4, 3'd7, 32'h0003_0000, 32'h0,         2'd2, 1'b0, 32'h0},          // R4 kind 7
        '{4'd4, 3'd1, 32'h0003_0000, 32'h0,         2'd0, 1'b1, 32'hA5A5_0F0F},  // R4 no effect
        '{4'd1, 3'd1, 32'h0000_0000, 32'h0,         2'd0, 1'b1, 32'h0}           // R1 r0 cleared
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // starts and ends just after a falling edge; samples in the strobe cycle
    task automatic issue(input logic [2:0] k, input logic [31:0] ins, input logic [31:0] wd,
                         output logic [1:0] r, output logic [31:0] d, output logic [31:0] st);
        cmd_valid = 1'b1; cmd_kind = k; cmd_instr = ins; cmd_wdata = wd;
        #1;
        r = rsp_code; d = rsp_rdata; st = tcyc;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic logic [31:0] dop(input int op, input int opnd);
        return {8'h00, 4'(op), 16'h0000, 4'(opnd)};
    endfunction

    task automatic wr_reg(input int idx, input logic [31:0] v);
        logic [1:0] r; logic [31:0] d, s;
        issue(3'd0, {12'h000, 4'(idx), 16'h0}, v, r, d, s);
    endtask

    initial begin : watchdog
        #(4 * 100000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [1:0]  r;
        logic [31:0] d, s, s2;

        repeat (3) @(negedge clk);
        #1;
        check("R1 fiq_n in reset", {31'b0, fiq_n}, 32'd1);
        check("R1 irq_n in reset", {31'b0, irq_n}, 32'd1);
        check("R1 idle code", {30'b0, rsp_code}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].kind, VEC[i].instr, VEC[i].wdata, r, d, s);
            check($sformatf("R%0d table %0d code", VEC[i].req, i), {30'b0, r}, {30'b0, VEC[i].rsp});
            if (VEC[i].chk_rd)
                check($sformatf("R%0d table %0d data", VEC[i].req, i), d, VEC[i].rd);
        end

        // R5: busy wait of 3 cycles; R6: strobes during the wait are dropped
        wr_reg(2, 32'd3);
        issue(3'd4, dop(0, 2), 32'h0, r, d, s);
        check("R5 wait strobe busy", {30'b0, r}, 32'd1);
        for (int k = 1; k <= 3; k++) begin
            cmd_valid = 1'b1; cmd_kind = 3'd0; cmd_instr = 32'h0004_0000; cmd_wdata = 32'hDEAD_BEEF;
            #1;
            check($sformatf("R6 wait cycle %0d code", k), {30'b0, rsp_code}, (k < 3) ? 32'd1 : 32'd0);
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        issue(3'd1, 32'h0004_0000, 32'h0, r, d, s);
        check("R6 write in wait dropped", d, 32'h0);
        check("R5 idle after wait", {30'b0, r}, 32'd0);

        // R5: zero count
        wr_reg(2, 32'd0);
        issue(3'd4, dop(0, 2), 32'h0, r, d, s);
        check("R5 zero wait done", {30'b0, r}, 32'd0);
        issue(3'd1, 32'h0007_0000, 32'h0, r, d, s);
        check("R5 no stall after zero", d, 32'h1234_5678);

        // R7: fast interrupt after 4 cycles
        wr_reg(6, 32'd4);
        issue(3'd4, dop(1, 6), 32'h0, r, d, s);
        for (int j = 0; j <= 4; j++) begin
            #1;
            check($sformatf("R7 fiq_n at +%0d", j + 1), {31'b0, fiq_n}, (j < 4) ? 32'd1 : 32'd0);
            @(negedge clk);
        end
        issue(3'd4, dop(3, 0), 32'h0, r, d, s);
        #1;
        check("R9 fiq released", {31'b0, fiq_n}, 32'd1);
        @(negedge clk);

        // R8: normal interrupt with zero count, then release
        issue(3'd4, dop(2, 0), 32'h0, r, d, s);
        #1;
        check("R8 irq_n zero count", {31'b0, irq_n}, 32'd0);
        @(negedge clk);
        issue(3'd4, dop(4, 0), 32'h0, r, d, s);
        #1;
        check("R9 irq released", {31'b0, irq_n}, 32'd1);
        @(negedge clk);

        // R9: release cancels a pending schedule
        issue(3'd4, dop(1, 6), 32'h0, r, d, s);
        issue(3'd4, dop(3, 0), 32'h0, r, d, s);
        for (int j = 0; j < 8; j++) begin
            #1;
            check("R9 cancelled fiq stays high", {31'b0, fiq_n}, 32'd1);
            @(negedge clk);
        end

        // R10: a longer reschedule replaces the pending shorter one
        wr_reg(8, 32'd10);
        issue(3'd4, dop(2, 6), 32'h0, r, d, s);
        issue(3'd4, dop(2, 8), 32'h0, r, d, s);
        for (int j = 0; j <= 10; j++) begin
            #1;
            check($sformatf("R10 irq_n at +%0d", j + 1), {31'b0, irq_n}, (j < 10) ? 32'd1 : 32'd0);
            @(negedge clk);
        end
        issue(3'd4, dop(4, 0), 32'h0, r, d, s);

        // R11: counter snapshot of the strobe cycle
        issue(3'd4, dop(5, 9), 32'h0, r, d, s);
        check("R11 stamp code", {30'b0, r}, 32'd0);
        issue(3'd1, 32'h0009_0000, 32'h0, r, d, s2);
        check("R11 stamp value", d, s);
        repeat (5) @(negedge clk);
        issue(3'd4, dop(5, 10), 32'h0, r, d, s);
        issue(3'd1, 32'h000A_0000, 32'h0, r, d, s2);
        check("R11 second stamp", d, s);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule